// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block steps through a ring of transmit buffer descriptors kept in a small half-word descriptor RAM. Each descriptor takes four half-words: a status/control word, a byte count, and the low and high halves of a 32-bit buffer address. When a ready descriptor is found, the block reads its fields and fetches the buffer bytes one at a time from an external byte memory. It hands each byte to a serial transmitter over a valid/ready handshake. When the last byte has been accepted, it writes the status word back with the ready bit cleared.

With no request pending, the block tests the current descriptor only when a poll interval, counted in clock cycles, has elapsed. After each descriptor it returns to waiting. Software can pulse a start-now command. The command register holds the command for exactly one clock and then clears itself. A command puts the block into a burst mode in which it services ready descriptors back to back, in ring order. Descriptors that become ready during the burst are picked up without a new command. The burst ends at the first descriptor found not ready, and periodic polling resumes from there.

Top module: `txdp_tx_poller`

## Requirements
- R1: While reset is held, tx_valid, ram_rd, ram_wr and demand_flag are all 0.
- R2: Without a command, a status read (ram_rd with ram_addr[1:0]=0) happens exactly POLL_CYCLES cycles after reset is released. It happens POLL_CYCLES+1 cycles after a status write-back made in poll mode.
- R3: A command pulse on demand_wr produces the status read of the current descriptor 2 cycles later, without waiting for the poll interval.
- R4: demand_flag goes high in the cycle after a demand_wr pulse and is low again one cycle later.
- R5: In burst mode, the status read of the next descriptor follows a write-back by 1 cycle. When a status word has bit 15 (ready) = 0, the block goes back to polling, and it re-reads that descriptor POLL_CYCLES+2 cycles after the failed read.
- R6: Descriptors are served in ascending index order. Descriptor i occupies half-word addresses 4i (status), 4i+1 (length), 4i+2 (address bits 15:0) and 4i+3 (address bits 31:16).
- R7: After serving a descriptor whose status bit 13 (wrap) is 1, or the last descriptor of the ring, the next index is 0.
- R8: A descriptor with address A and length N sends the bytes at A, A+1, …, A+N-1 in that order. tx_data is held stable while tx_valid is high and tx_ready is low.
- R9: The only RAM write for a descriptor goes to its status address. It writes the fetched status with bit 15 cleared, after the last byte has been accepted. The length word is never written.
- R10: A ready descriptor with length 0 is written back as closed without any byte being sent.
- R11: A descriptor made ready while an earlier one is being sent in burst mode is served without a new command.
- R12: When the first served descriptor is ready and the block is idle, tx_valid first rises 9 cycles after the demand_wr pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| demand_wr | input | 1 | One-cycle write of the start-now command |
| demand_flag | output | 1 | Current value of the self-clearing command register |
| ram_rd | output | 1 | Descriptor RAM read strobe (data next cycle) |
| ram_wr | output | 1 | Descriptor RAM write strobe |
| ram_addr | output | IDX_W+2 | Descriptor RAM half-word address |
| ram_wdata | output | 16 | Descriptor RAM write data |
| ram_rdata | input | 16 | Descriptor RAM read data, one cycle after ram_rd |
| buf_rd | output | 1 | Buffer byte read strobe (data next cycle) |
| buf_addr | output | 32 | Buffer byte address |
| buf_rdata | input | 8 | Buffer byte read data |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Byte value |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The hardest situation to reach is a descriptor that changes from not ready to ready in the middle of a burst. The status read for it has to land after the change and before the burst gives up. The bench therefore marks that descriptor ready as soon as it sees the first byte of the preceding descriptor accepted, which leaves several stalled byte transfers before the status read. A second burst readies every descriptor in the ring so that the service order, the end-of-ring wrap and the stop at an already-closed descriptor are all observed in one sweep. Cycle gaps between status reads are compared with exact counts derived from the poll interval.

// File: rtl/txdp_pkg.sv
// Shared definitions for the transmit descriptor poller.
// Assumes a descriptor of four half-words: status, length, addr low, addr high.
package txdp_pkg;

    localparam int READY_BIT = 15;
    localparam int WRAP_BIT  = 13;

    localparam logic [1:0] OFF_STATUS = 2'd0;
    localparam logic [1:0] OFF_LENGTH = 2'd1;
    localparam logic [1:0] OFF_ADDRLO = 2'd2;
    localparam logic [1:0] OFF_ADDRHI = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RSTAT,
        S_RLEN,
        S_RPLO,
        S_RPHI,
        S_SETUP,
        S_FETCH,
        S_LOAD,
        S_SEND,
        S_WB
    } txdp_state_t;

endpackage

// File: rtl/txdp_poll_timer.sv
// Poll interval timer: counts cycles while run_i is high and raises expire_o
// in the cycle the interval is complete. Restarts from zero whenever run_i drops.
// Assumes POLL_CYCLES >= 2.
module txdp_poll_timer #(
    parameter int POLL_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expire_o
);
    localparam int CW = $clog2(POLL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign expire_o = run_i && (cnt_q == LAST);

    // Count idle cycles; clear when stopped or at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || expire_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_POLL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o); // R2

endmodule

// File: rtl/txdp_demand_reg.sv
// Start-now command register: set by a software write, cleared by itself
// one clock later. Assumes set_i is a single-cycle write strobe.
module txdp_demand_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    output logic flag_o
);
    // Capture the write; with no new write the flag falls back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            flag_o <= set_i;
        end
    end

    AST_DEMAND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !$past(set_i, 2) |=> !flag_o); // R4

endmodule

// File: rtl/txdp_ring_index.sv
// Ring index of the current descriptor. Advances after each serviced
// descriptor and returns to zero on a wrap mark or at the end of the ring.
// Assumes RING_SIZE between 2 and 128.
module txdp_ring_index #(
    parameter int RING_SIZE = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance_i,
    input  logic                         wrap_i,
    output logic [$clog2(RING_SIZE)-1:0] idx_o
);
    localparam int IDX_W = $clog2(RING_SIZE);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_SIZE - 1);

    // Step to the next descriptor or back to the ring base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o <= '0;
        end else if (advance_i) begin
            if (wrap_i || idx_o == LAST_IDX) begin
                idx_o <= '0;
            end else begin
                idx_o <= idx_o + 1'b1;
            end
        end
    end

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && wrap_i |=> idx_o == '0); // R7

    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(idx_o)); // R6

endmodule

// File: rtl/txdp_tx_poller.sv
// Transmit descriptor poller, top level. Waits for the poll interval or a
// start-now command, reads the current descriptor, streams its buffer bytes
// to the transmitter, then writes back the status with the ready bit cleared.
// A command keeps the block running back to back until a descriptor is found
// not ready. Assumes descriptor RAM and buffer memory answer one cycle after
// their read strobes.
module txdp_tx_poller
    import txdp_pkg::*;
#(
    parameter int RING_SIZE   = 16,
    parameter int POLL_CYCLES = 200,
    parameter int IDX_W       = $clog2(RING_SIZE),
    parameter int RAM_AW      = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              demand_wr,
    output logic              demand_flag,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [15:0]       ram_wdata,
    input  logic [15:0]       ram_rdata,
    output logic              buf_rd,
    output logic [31:0]       buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready
);
    txdp_state_t      state_q, state_d;
    logic [15:0]      status_q, len_q, ptr_lo_q, bcnt_q;
    logic [31:0]      ptr_q;
    logic [7:0]       byte_q;
    logic             burst_q;
    logic             dmd_q, poll_due;
    logic [IDX_W-1:0] idx;
    logic [1:0]       off;
    logic             last_byte;

    txdp_demand_reg u_dmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (demand_wr),
        .flag_o (dmd_q)
    );

    txdp_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (state_q == S_IDLE),
        .expire_o (poll_due)
    );

    txdp_ring_index #(.RING_SIZE(RING_SIZE)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (state_q == S_WB),
        .wrap_i    (status_q[WRAP_BIT]),
        .idx_o     (idx)
    );

    assign demand_flag = dmd_q;
    assign last_byte   = (bcnt_q == len_q - 16'd1);

    // Pick the half-word offset each state touches in the descriptor.
    always_comb begin
        case (state_q)
            S_RLEN:  off = OFF_LENGTH;
            S_RPLO:  off = OFF_ADDRLO;
            S_RPHI:  off = OFF_ADDRHI;
            default: off = OFF_STATUS;
        endcase
    end

    assign ram_rd    = (state_q == S_RSTAT) || (state_q == S_RLEN) ||
                       (state_q == S_RPLO)  || (state_q == S_RPHI);
    assign ram_wr    = (state_q == S_WB);
    assign ram_addr  = {idx, off};
    assign ram_wdata = status_q & ~(16'd1 << READY_BIT);
    assign buf_rd    = (state_q == S_FETCH);
    assign buf_addr  = ptr_q + {16'd0, bcnt_q};
    assign tx_valid  = (state_q == S_SEND);
    assign tx_data   = byte_q;

    // Next-state selection of the descriptor walk.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (dmd_q || poll_due) state_d = S_RSTAT;
            S_RSTAT: state_d = S_RLEN;
            S_RLEN: begin
                if (ram_rdata[READY_BIT]) state_d = S_RPLO;
                else if (dmd_q)           state_d = S_RSTAT;
                else                      state_d = S_IDLE;
            end
            S_RPLO:  state_d = S_RPHI;
            S_RPHI:  state_d = S_SETUP;
            S_SETUP: state_d = (len_q == 16'd0) ? S_WB : S_FETCH;
            S_FETCH: state_d = S_LOAD;
            S_LOAD:  state_d = S_SEND;
            S_SEND: begin
                if (tx_ready) state_d = last_byte ? S_WB : S_FETCH;
            end
            S_WB:    state_d = (burst_q || dmd_q) ? S_RSTAT : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Burst mode: entered on a command, left at a descriptor not ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
        end else if (dmd_q) begin
            burst_q <= 1'b1;
        end else if (state_q == S_RLEN && !ram_rdata[READY_BIT]) begin
            burst_q <= 1'b0;
        end
    end

    // Capture descriptor fields as they return and track the byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            len_q    <= '0;
            ptr_lo_q <= '0;
            ptr_q    <= '0;
            bcnt_q   <= '0;
            byte_q   <= '0;
        end else begin
            case (state_q)
                S_RLEN:  status_q <= ram_rdata;
                S_RPLO:  len_q    <= ram_rdata;
                S_RPHI:  ptr_lo_q <= ram_rdata;
                S_SETUP: begin
                    ptr_q  <= {ram_rdata, ptr_lo_q};
                    bcnt_q <= '0;
                end
                S_LOAD:  byte_q <= buf_rdata;
                S_SEND:  if (tx_ready) bcnt_q <= bcnt_q + 16'd1;
                default: ;
            endcase
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R8

    AST_WB_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr && len_q != 16'd0 |-> $past(tx_valid && tx_ready)); // R9

    AST_WB_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> !ram_wdata[READY_BIT]); // R9

    AST_EMPTY_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_SETUP && len_q == 16'd0 |=> !tx_valid && ram_wr); // R10

    AST_BURST_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr && burst_q |=> ram_rd && ram_addr[1:0] == OFF_STATUS); // R5

    AST_START_ON_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        dmd_q && state_q == S_IDLE |=> ram_rd); // R3

endmodule

// File: tb/txdp_tx_poller_tb_top.sv
module txdp_tx_poller_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int RING       = 8;
    localparam int POLL       = 40;
    localparam int IDX_W      = $clog2(RING);
    localparam int RAM_AW     = IDX_W + 2;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              demand_wr = 1'b0;
    logic              demand_flag;
    logic              ram_rd, ram_wr;
    logic [RAM_AW-1:0] ram_addr;
    logic [15:0]       ram_wdata;
    logic [15:0]       ram_rdata = '0;
    logic              buf_rd;
    logic [31:0]       buf_addr;
    logic [7:0]        buf_rdata = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;

    txdp_tx_poller #(.RING_SIZE(RING), .POLL_CYCLES(POLL)) dut_i (
        .clk(clk), .rst_n(rst_n), .demand_wr(demand_wr), .demand_flag(demand_flag),
        .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata), .buf_rd(buf_rd), .buf_addr(buf_addr),
        .buf_rdata(buf_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bytef(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    // Descriptor RAM and buffer memory models
    logic [15:0] mem [0:(1<<RAM_AW)-1];
    always @(posedge clk) begin
        if (ram_wr) mem[ram_addr] <= ram_wdata;
        if (ram_rd) ram_rdata <= mem[ram_addr];
        if (buf_rd) buf_rdata <= bytef(buf_addr);
    end

    // Event logs
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int rd_n = 0, tx_n = 0, wr_n = 0, flag_hi = 0;
    int rd_idx [0:63];
    int rd_cyc [0:63];
    logic [7:0]  tx_log [0:63];
    int wr_idx [0:63];
    logic [15:0] wr_dat [0:63];
    int wr_txn [0:63];
    int wr_cyc [0:63];
    logic [15:0] len_snap [0:63];

    always @(negedge clk) begin
        tx_ready = (cyc % 3) != 1;
        if (rst_n) begin
            if (ram_rd && ram_addr[1:0] == 2'd0 && rd_n < 64) begin
                rd_idx[rd_n] = int'(ram_addr >> 2);
                rd_cyc[rd_n] = cyc;
                rd_n++;
            end
            if (tx_valid && tx_ready && tx_n < 64) begin
                tx_log[tx_n] = tx_data;
                tx_n++;
            end
            if (ram_wr && wr_n < 64) begin
                wr_idx[wr_n] = int'(ram_addr >> 2);
                wr_dat[wr_n] = ram_wdata;
                wr_txn[wr_n] = tx_n;
                wr_cyc[wr_n] = cyc;
                len_snap[wr_n] = (ram_addr[1:0] == 2'd0) ? mem[ram_addr + 1] : 16'hDEAD;
                wr_n++;
            end
            if (demand_flag) flag_hi++;
        end
    end

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic set_desc(input int i, input logic [15:0] st, input logic [15:0] len,
                            input logic [31:0] ptr);
        mem[4*i]   = st;
        mem[4*i+1] = len;
        mem[4*i+2] = ptr[15:0];
        mem[4*i+3] = ptr[31:16];
    endtask

    task automatic pulse_demand(output int at);
        @(negedge clk);
        demand_wr = 1'b1;
        at = cyc;
        @(negedge clk);
        demand_wr = 1'b0;
    endtask

    task automatic check_bytes(input int first, input logic [31:0] ptr, input int len,
                               input string req);
        for (int k = 0; k < len; k++)
            chk(tx_log[first+k] == bytef(ptr + 32'(k)), req,
                tx_log[first+k], bytef(ptr + 32'(k)));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int c0, dmd, base_rd, base_wr, base_tx, waitc;
        for (int a = 0; a < (1 << RAM_AW); a++) mem[a] = '0;
        set_desc(0, 16'h8042, 16'd3, 32'h0000_0100);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!tx_valid, "R1 tx_valid", tx_valid, 0);
        chk(!ram_rd, "R1 ram_rd", ram_rd, 0);
        chk(!ram_wr, "R1 ram_wr", ram_wr, 0);
        chk(!demand_flag, "R1 demand_flag", demand_flag, 0);
        rst_n = 1'b1;
        c0 = cyc;

        // R2: first poll after exactly POLL cycles
        while (rd_n < 1) @(negedge clk);
        chk(rd_idx[0] == 0, "R6 first index", rd_idx[0], 0);
        chk(rd_cyc[0] - c0 == POLL, "R2 first poll delay", rd_cyc[0] - c0, POLL);

        while (wr_n < 1) @(negedge clk);
        chk(wr_idx[0] == 0, "R9 wb index", wr_idx[0], 0);
        chk(wr_dat[0] == 16'h0042, "R9 wb value", wr_dat[0], 16'h0042);
        chk(wr_txn[0] == 3, "R9 wb after last byte", wr_txn[0], 3);
        chk(len_snap[0] == 16'd3, "R9 length untouched", len_snap[0], 3);
        check_bytes(0, 32'h0000_0100, 3, "R8 bytes desc0");

        while (rd_n < 2) @(negedge clk);
        chk(rd_idx[1] == 1, "R6 next index", rd_idx[1], 1);
        chk(rd_cyc[1] - wr_cyc[0] == POLL + 1, "R2 poll after wb",
            rd_cyc[1] - wr_cyc[0], POLL + 1);

        // Burst on demand: R3 R4 R5 R10 R11 R7
        repeat (3) @(negedge clk);
        set_desc(1, 16'h8011, 16'd0, 32'h0);
        set_desc(2, 16'h8000, 16'd4, 32'h1234_00FE);
        set_desc(3, 16'h0005, 16'd2, 32'h0000_0300);
        base_rd = rd_n;
        flag_hi = 0;
        pulse_demand(dmd);
        while (rd_n <= base_rd) @(negedge clk);
        chk(rd_idx[base_rd] == 1, "R3 demand index", rd_idx[base_rd], 1);
        chk(rd_cyc[base_rd] - dmd == 2, "R3 demand delay", rd_cyc[base_rd] - dmd, 2);
        chk(flag_hi == 1, "R4 flag one cycle", flag_hi, 1);

        while (tx_n < 4) @(negedge clk);
        mem[12] = 16'hA005; // R11: ready with wrap, set mid-burst
        while (wr_n < 4) @(negedge clk);
        chk(wr_idx[1] == 1 && wr_dat[1] == 16'h0011, "R10 empty closed", wr_dat[1], 16'h0011);
        chk(wr_txn[1] == 3, "R10 no bytes", wr_txn[1], 3);
        chk(wr_idx[2] == 2 && wr_txn[2] == 7, "R8 desc2 count", wr_txn[2], 7);
        check_bytes(3, 32'h1234_00FE, 4, "R8 bytes desc2");
        chk(wr_idx[3] == 3 && wr_dat[3] == 16'h2005, "R11 late desc served", wr_dat[3], 16'h2005);
        check_bytes(7, 32'h0000_0300, 2, "R11 bytes desc3");

        base_rd = rd_n;
        while (rd_n < base_rd + 1) @(negedge clk);
        chk(rd_idx[base_rd - 1] == 3, "R5 desc3 read in burst", rd_idx[base_rd - 1], 3);
        chk(rd_cyc[base_rd - 1] - wr_cyc[2] == 1, "R5 back to back",
            rd_cyc[base_rd - 1] - wr_cyc[2], 1);
        chk(rd_idx[base_rd] == 0, "R7 wrap bit", rd_idx[base_rd], 0);
        chk(rd_cyc[base_rd] - wr_cyc[3] == 1, "R5 burst continues",
            rd_cyc[base_rd] - wr_cyc[3], 1);
        while (rd_n < base_rd + 2) @(negedge clk);
        chk(rd_cyc[base_rd+1] - rd_cyc[base_rd] == POLL + 2, "R5 back to polling",
            rd_cyc[base_rd+1] - rd_cyc[base_rd], POLL + 2);

        // Full ring sweep: R6 R7 R12
        repeat (3) @(negedge clk);
        for (int i = 0; i < RING; i++)
            set_desc(i, 16'h8000 | 16'(i), 16'd1, 32'h400 + 32'(16*i));
        base_rd = rd_n;
        base_wr = wr_n;
        base_tx = tx_n;
        pulse_demand(dmd);
        waitc = cyc;
        while (!tx_valid) @(negedge clk);
        chk(cyc - dmd == 9, "R12 first byte latency", cyc - dmd, 9);
        while (wr_n < base_wr + RING) @(negedge clk);
        for (int i = 0; i < RING; i++) begin
            chk(wr_idx[base_wr+i] == i, "R6 ring order", wr_idx[base_wr+i], i);
            chk(wr_dat[base_wr+i] == 16'(i), "R9 sweep wb", wr_dat[base_wr+i], i);
        end
        for (int i = 0; i < RING; i++)
            check_bytes(base_tx + i, 32'h400 + 32'(16*i), 1, "R8 sweep bytes");
        while (rd_n < base_rd + RING + 1) @(negedge clk);
        chk(rd_idx[base_rd+RING] == 0, "R7 end of ring wrap", rd_idx[base_rd+RING], 0);
        repeat (5) @(negedge clk);
        chk(wr_n == base_wr + RING, "R5 stops at closed desc", wr_n, base_wr + RING);
        chk(!tx_valid && waitc > 0, "R5 idle after stop", tx_valid, 0);

        summary();
        $finish;
    end

endmodule